// File: doc/BRIEF.md
# Nonvolatile Shadow SRAM Controller

This block is a byte-wide static memory in which every word has a nonvolatile shadow word behind it. In normal operation it is an ordinary synchronous read/write memory driven by chip enable, write enable, output enable, a 13-bit address and separate data-in and data-out buses. A third signal, `dataOe`, stands in for a three-state bus: the output bus is driven only while `dataOe` is high.

Two bulk transfers move data between the working array and the shadow array. A save copies every working word into its shadow word. A restore first clears every working word to zero and then copies the shadow words back. The shadow array never changes during a restore, so a restore can be repeated any number of times. A save starts when `powerFail` rises. A restore starts when `powerGood` rises. Either one can also be started by reading a fixed sequence of six addresses. A write or a wrong read in the middle of the sequence aborts it. While a transfer runs, `busy` is high and user accesses are ignored.

The full-size part has 8192 words (`MEM_AW` = 13). The default build uses a smaller array. The unlock sequence always decodes all 13 address bits, and the working array is indexed by the low `MEM_AW` bits. Each transfer walks the array one word per cycle and then waits `WAIT_CYC` extra cycles.

Top module: `nvsram_shadow`

## Requirements
- R1: When `chipEn` and `writeEn` are high at a clock edge, `dataIn` is written to the word at `addr`. When `chipEn` and `outEn` are high and `writeEn` is low, the word is read: `dataOut` holds it and `dataOe` is high for the one cycle after that edge. In every other cycle `dataOe` is low.
- R2: User writes never change the shadow array. A restore returns the value held at the last save, not any value written after it.
- R3: Reading the addresses 0x0E38, 0x11C7, 0x03E0, 0x1C1F, 0x0303 and 0x1FC0 in that order starts a save. `busy` rises at the second clock edge after the sixth read and stays high for 2**MEM_AW + WAIT_CYC cycles.
- R4: Reading the same first five addresses and then 0x1C63 starts a restore with the same start timing. `busy` stays high for 2*2**MEM_AW + WAIT_CYC cycles. Afterwards every working word equals its shadow word.
- R5: A write, or a read of any address other than the next one in the sequence, resets the unlock sequence. No transfer follows.
- R6: While `busy` is high, writes have no effect and reads do not raise `dataOe`.
- R7: A rising edge of `powerFail` while idle starts a save on the next edge. The save lasts 2**MEM_AW + WAIT_CYC cycles and is not interrupted.
- R8: A rising edge of `powerGood` while idle starts a restore on the next edge, with the duration given in R4.
- R9: A restore clears words to zero in ascending address order before any shadow data is loaded. An interrupted restore leaves the low words at zero and leaves the words not yet reached unchanged.
- R10: A rising edge of `powerFail` during the clear or load walk of a restore ends the transfer at the next edge (`busy` falls), and no save is performed.
- R11: Repeated restores with no save in between give the same contents.
- R12: After reset, `busy`, `dataOe` and `dataOut` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chipEn | input | 1 | Chip enable, active high |
| writeEn | input | 1 | Write enable, active high |
| outEn | input | 1 | Output enable, active high |
| addr | input | 13 | Word address |
| dataIn | input | 8 | Write data |
| dataOut | output | 8 | Read data |
| dataOe | output | 1 | Output bus drive enable |
| powerFail | input | 1 | Power-loss indication; a rising edge requests a save |
| powerGood | input | 1 | Power-up indication; a rising edge requests a restore |
| busy | output | 1 | High while a save or restore runs |

## Verification
The embedded assertions check, on every cycle, the properties that hold cycle by cycle. The output bus is never driven while busy. A user write never coincides with a transfer strobe. At most one transfer strobe is active at a time. A running save is never cut short. A power failure during a restore returns the controller to idle on the next edge. A write always resets the unlock sequence. The bench scenarios are needed for the end-to-end properties. These are the exact busy durations, the two-edge start latency after the sixth read, the partial contents left by an interrupted restore, and the proof that no save followed that abort. They also show that restores can be repeated and that later writes never reach the shadow array.

// File: rtl/nvsram_pkg.sv
package nvsram_pkg;

  localparam int AddrW  = 13;
  localparam int SeqLen = 6;

  typedef struct packed {
    logic userRd;
    logic userWr;
    logic clrWord;
    logic storeWord;
    logic loadWord;
  } memStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STORE, ST_CLEAR, ST_LOAD, ST_WAIT
  } xferState_t;

  localparam logic [AddrW-1:0] SaveLast    = 13'h1FC0;
  localparam logic [AddrW-1:0] RestoreLast = 13'h1C63;

  function automatic logic [AddrW-1:0] seqAddr(input logic [2:0] idx);
    case (idx)
      3'd0:    seqAddr = 13'h0E38;
      3'd1:    seqAddr = 13'h11C7;
      3'd2:    seqAddr = 13'h03E0;
      3'd3:    seqAddr = 13'h1C1F;
      default: seqAddr = 13'h0303;
    endcase
  endfunction

endpackage

// File: rtl/nvsram_unlock.sv
module nvsram_unlock
  import nvsram_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdAcc,
  input  logic             wrAcc,
  input  logic [AddrW-1:0] addr,
  output logic             swStore,
  output logic             swRecall
);

  logic [2:0] step;
  logic       firstHit;

  assign firstHit = (addr == seqAddr(3'd0));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step     <= '0;
      swStore  <= 1'b0;
      swRecall <= 1'b0;
    end else begin
      swStore  <= 1'b0;
      swRecall <= 1'b0;
      if (wrAcc) begin
        step <= '0;
      end else if (rdAcc) begin
        if (step == 3'(SeqLen - 1)) begin
          if (addr == SaveLast)         swStore  <= 1'b1;
          else if (addr == RestoreLast) swRecall <= 1'b1;
          step <= firstHit ? 3'd1 : 3'd0;
        end else if (addr == seqAddr(step)) begin
          step <= step + 3'd1;
        end else begin
          step <= firstHit ? 3'd1 : 3'd0;
        end
      end
    end
  end

  AST_WRITE_CLEARS_SEQ: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc |=> (step == 3'd0 && !swStore && !swRecall)); // R5
  AST_ONE_SW_START: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({swStore, swRecall})); // R3

endmodule

// File: rtl/nvsram_ctrl.sv
module nvsram_ctrl
  import nvsram_pkg::*;
#(
  parameter int MEM_AW   = 8,
  parameter int WAIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              writeEn,
  input  logic              outEn,
  input  logic              powerFail,
  input  logic              powerGood,
  input  logic              swStore,
  input  logic              swRecall,
  output memStrobe_t        strobe,
  output logic [MEM_AW-1:0] walkPtr,
  output logic              rdAcc,
  output logic              wrAcc,
  output logic              busy
);

  localparam int WaitW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;
  localparam logic [MEM_AW-1:0] PtrMax = '1;

  xferState_t       state;
  logic [WaitW-1:0] waitCnt;
  logic             pfPrev, pgPrev, pfRise, pgRise;
  logic             idle, startStore, startRecall, startNow;
  xferState_t       afterWalk;

  assign pfRise      = powerFail & ~pfPrev;
  assign pgRise      = powerGood & ~pgPrev;
  assign idle        = (state == ST_IDLE);
  assign startStore  = idle & (pfRise | swStore);
  assign startRecall = idle & ~pfRise & ~swStore & (pgRise | swRecall);
  assign startNow    = startStore | startRecall;
  assign afterWalk   = (WAIT_CYC == 0) ? ST_IDLE : ST_WAIT;

  assign rdAcc = idle & ~startNow & chipEn & ~writeEn & outEn;
  assign wrAcc = idle & ~startNow & chipEn & writeEn;
  assign busy  = ~idle;

  always_comb begin
    strobe.userRd    = rdAcc;
    strobe.userWr    = wrAcc;
    strobe.storeWord = (state == ST_STORE);
    strobe.clrWord   = (state == ST_CLEAR) & ~pfRise;
    strobe.loadWord  = (state == ST_LOAD) & ~pfRise;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      walkPtr <= '0;
      waitCnt <= '0;
      pfPrev  <= 1'b0;
      pgPrev  <= 1'b0;
    end else begin
      pfPrev <= powerFail;
      pgPrev <= powerGood;
      case (state)
        ST_IDLE: begin
          walkPtr <= '0;
          waitCnt <= '0;
          if (startStore)       state <= ST_STORE;
          else if (startRecall) state <= ST_CLEAR;
        end
        ST_STORE: begin
          walkPtr <= walkPtr + 1'b1;
          if (walkPtr == PtrMax) state <= afterWalk;
        end
        ST_CLEAR: begin
          if (pfRise) state <= ST_IDLE;
          else begin
            walkPtr <= walkPtr + 1'b1;
            if (walkPtr == PtrMax) state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (pfRise) state <= ST_IDLE;
          else begin
            walkPtr <= walkPtr + 1'b1;
            if (walkPtr == PtrMax) state <= afterWalk;
          end
        end
        ST_WAIT: begin
          waitCnt <= waitCnt + 1'b1;
          if (int'(waitCnt) == WAIT_CYC - 1) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_SAVE_UNBROKEN: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STORE && walkPtr != PtrMax) |=> (state == ST_STORE)); // R7
  AST_RESTORE_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_CLEAR || state == ST_LOAD) && pfRise) |=> (state == ST_IDLE)); // R10
  AST_CLEAR_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> ($past(state) == ST_CLEAR || $past(state) == ST_LOAD)); // R9

endmodule

// File: rtl/nvsram_datapath.sv
module nvsram_datapath
  import nvsram_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strobe,
  input  logic [MEM_AW-1:0] walkPtr,
  input  logic [MEM_AW-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int Depth = 2 ** MEM_AW;

  logic [DATA_W-1:0] sramMem   [Depth];
  logic [DATA_W-1:0] shadowMem [Depth];

  always_ff @(posedge clk) begin
    if (strobe.userWr)        sramMem[addr]    <= dataIn;
    else if (strobe.clrWord)  sramMem[walkPtr] <= '0;
    else if (strobe.loadWord) sramMem[walkPtr] <= shadowMem[walkPtr];
    if (strobe.storeWord)     shadowMem[walkPtr] <= sramMem[walkPtr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe <= strobe.userRd;
      if (strobe.userRd) dataOut <= sramMem[addr];
    end
  end

  AST_USER_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.userWr || strobe.userRd) |-> !(strobe.clrWord || strobe.loadWord || strobe.storeWord)); // R6
  AST_ONE_WALK_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.clrWord, strobe.loadWord, strobe.storeWord})); // R4

endmodule

// File: rtl/nvsram_shadow.sv
module nvsram_shadow
  import nvsram_pkg::*;
#(
  parameter int MEM_AW   = 8,
  parameter int DATA_W   = 8,
  parameter int WAIT_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEn,
  input  logic              writeEn,
  input  logic              outEn,
  input  logic [AddrW-1:0]  addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  input  logic              powerFail,
  input  logic              powerGood,
  output logic              busy
);

  memStrobe_t        strobe;
  logic [MEM_AW-1:0] walkPtr;
  logic              rdAcc, wrAcc, swStore, swRecall;

  nvsram_unlock uUnlock (
    .clk(clk), .rstN(rstN), .rdAcc(rdAcc), .wrAcc(wrAcc), .addr(addr),
    .swStore(swStore), .swRecall(swRecall)
  );

  nvsram_ctrl #(.MEM_AW(MEM_AW), .WAIT_CYC(WAIT_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .writeEn(writeEn), .outEn(outEn),
    .powerFail(powerFail), .powerGood(powerGood), .swStore(swStore),
    .swRecall(swRecall), .strobe(strobe), .walkPtr(walkPtr), .rdAcc(rdAcc),
    .wrAcc(wrAcc), .busy(busy)
  );

  nvsram_datapath #(.MEM_AW(MEM_AW), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .walkPtr(walkPtr),
    .addr(addr[MEM_AW-1:0]), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !dataOe); // R6

endmodule

// File: tb/tb_nvsram_shadow.sv
module tb_nvsram_shadow;

  localparam int MemAw  = 8;
  localparam int WaitC  = 4;
  localparam int SaveCyc    = (2 ** MemAw) + WaitC;
  localparam int RestoreCyc = 2 * (2 ** MemAw) + WaitC;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipEn = 1'b0, writeEn = 1'b0, outEn = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  dataIn = '0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic        powerFail = 1'b0, powerGood = 1'b0;
  logic        busy;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  nvsram_shadow #(.MEM_AW(MemAw), .DATA_W(8), .WAIT_CYC(WaitC)) dut (
    .clk(clk), .rstN(rstN), .chipEn(chipEn), .writeEn(writeEn), .outEn(outEn),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .powerFail(powerFail), .powerGood(powerGood), .busy(busy)
  );

  // vector: [21] write, [20:8] address, [7:0] data or expected read value
  localparam logic [21:0] VECS [8] = '{
    {1'b1, 13'h0005, 8'hA5}, {1'b1, 13'h0006, 8'h3C}, {1'b1, 13'h00FF, 8'h81},
    {1'b0, 13'h0005, 8'hA5}, {1'b0, 13'h00FF, 8'h81}, {1'b1, 13'h0005, 8'h5A},
    {1'b0, 13'h0005, 8'h5A}, {1'b0, 13'h0006, 8'h3C}
  };

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk);
    chipEn = 1'b1; writeEn = 1'b1; outEn = 1'b0; addr = a; dataIn = d;
    @(negedge clk);
    chipEn = 1'b0; writeEn = 1'b0;
  endtask

  task automatic doRead(input logic [12:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    chipEn = 1'b1; writeEn = 1'b0; outEn = 1'b1; addr = a;
    @(negedge clk);
    d = dataOut; oe = dataOe;
    chipEn = 1'b0; outEn = 1'b0;
  endtask

  task automatic runSeq(input logic [12:0] last);
    logic [7:0] d; logic oe;
    doRead(13'h0E38, d, oe); doRead(13'h11C7, d, oe); doRead(13'h03E0, d, oe);
    doRead(13'h1C1F, d, oe); doRead(13'h0303, d, oe); doRead(last, d, oe);
  endtask

  task automatic countBusy(output int n);
    n = 0;
    @(negedge clk);
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic finish();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        nChecks++; nFails++;
        $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
        finish();
      end
    end
  end

  initial begin
    logic [7:0] d; logic oe; int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    check("R12 busy", busy, 0);
    check("R12 dataOe", dataOe, 0);
    check("R12 dataOut", dataOut, 0);

    // R1 vector walk
    foreach (VECS[i]) begin
      if (VECS[i][21]) doWrite(VECS[i][20:8], VECS[i][7:0]);
      else begin
        doRead(VECS[i][20:8], d, oe);
        check("R1 read data", d, VECS[i][7:0]);
        check("R1 dataOe on", oe, 1);
      end
    end
    @(negedge clk);
    check("R1 dataOe off", dataOe, 0);

    // R3 software save
    for (int k = 0; k < 4; k++) doWrite(13'(16 + k), 8'(17 * (k + 1)));
    runSeq(13'h1FC0);
    check("R3 no busy before second edge", busy, 0);
    countBusy(n);
    check("R3 save length", n, SaveCyc);

    // R2 / R4 software restore
    doWrite(13'h0010, 8'hEE);
    doRead(13'h0010, d, oe);
    check("R2 new value readable", d, 8'hEE);
    runSeq(13'h1C63);
    countBusy(n);
    check("R4 restore length", n, RestoreCyc);
    doRead(13'h0010, d, oe);
    check("R2 shadow kept saved value", d, 8'h11);
    doRead(13'h0013, d, oe);
    check("R4 restored word", d, 8'h44);

    // R11 repeat restore
    doWrite(13'h0010, 8'h99);
    runSeq(13'h1C63);
    countBusy(n);
    doRead(13'h0010, d, oe);
    check("R11 second restore", d, 8'h11);

    // R5 aborts: write mid-sequence, then stray read mid-sequence
    doRead(13'h0E38, d, oe); doRead(13'h11C7, d, oe); doRead(13'h03E0, d, oe);
    doWrite(13'h0040, 8'h01);
    doRead(13'h1C1F, d, oe); doRead(13'h0303, d, oe); doRead(13'h1FC0, d, oe);
    repeat (3) @(negedge clk);
    check("R5 write aborts sequence", busy, 0);
    doRead(13'h0E38, d, oe); doRead(13'h11C7, d, oe); doRead(13'h0000, d, oe);
    doRead(13'h03E0, d, oe); doRead(13'h1C1F, d, oe); doRead(13'h0303, d, oe);
    doRead(13'h1C63, d, oe);
    repeat (3) @(negedge clk);
    check("R5 stray read aborts sequence", busy, 0);

    // R6 lockout during a save
    doWrite(13'h0020, 8'h5A);
    runSeq(13'h1FC0);
    @(negedge clk);
    check("R6 busy started", busy, 1);
    chipEn = 1'b1; writeEn = 1'b1; addr = 13'h0020; dataIn = 8'hA5;
    repeat (4) @(negedge clk);
    writeEn = 1'b0; outEn = 1'b1;
    repeat (4) begin
      @(negedge clk);
      check("R6 bus quiet while busy", dataOe, 0);
    end
    chipEn = 1'b0; outEn = 1'b0;
    while (busy) @(negedge clk);
    doRead(13'h0020, d, oe);
    check("R6 write ignored while busy", d, 8'h5A);

    // R7 power-fail save
    doWrite(13'h0030, 8'h77);
    @(negedge clk);
    powerFail = 1'b1;
    countBusy(n);
    check("R7 power-fail save length", n, SaveCyc);
    powerFail = 1'b0;
    doWrite(13'h0030, 8'h00);

    // R8 power-up restore
    @(negedge clk);
    powerGood = 1'b1;
    countBusy(n);
    check("R8 power-up restore length", n, RestoreCyc);
    doRead(13'h0030, d, oe);
    check("R8 restored value", d, 8'h77);
    powerGood = 1'b0;

    // R9 / R10 interrupted restore
    doWrite(13'h0080, 8'h3C);
    doWrite(13'h0005, 8'h66);
    doWrite(13'h0030, 8'h00);
    @(negedge clk);
    powerGood = 1'b1;
    repeat (10) @(negedge clk);
    check("R10 restore running", busy, 1);
    powerFail = 1'b1;
    @(negedge clk);
    check("R10 abort ends transfer", busy, 0);
    repeat (2) @(negedge clk);
    check("R10 no save started", busy, 0);
    powerFail = 1'b0;
    doRead(13'h0000, d, oe);
    check("R9 low word cleared", d, 8'h00);
    doRead(13'h0005, d, oe);
    check("R9 word five cleared", d, 8'h00);
    doRead(13'h0080, d, oe);
    check("R9 unreached word unchanged", d, 8'h3C);
    runSeq(13'h1C63);
    countBusy(n);
    doRead(13'h0030, d, oe);
    check("R10 shadow not overwritten", d, 8'h77);

    finish();
  end

endmodule